// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Master/Slave Roles and Bus-Conflict Fallback

This block is a byte-wide serial peripheral interface unit. A processor drives it through a small register bus made of three registers: control, status and data. As bus master it makes SCK from the system clock with a power-of-two divider. As a slave it follows an external SCK. Both roles move eight bits out and eight bits in at the same time, most significant bit first. Clock polarity and phase can each be selected.

Writing the data register starts a byte. When the byte ends, a completion flag rises and can raise an interrupt. The way the flag clears depends on whether the interrupt is enabled. If the interrupt is on, an acknowledge pulse clears it. If the interrupt is off, the processor must read the status register and then access the data register.

The select input is active low and is used only when the select-enable bit is set. In the master role, a low select means that another master has taken the bus. The unit then gives up the master role and becomes a slave. In the slave role, a high select stops the shift logic and resets it. A sticky flag records that the select input was seen high.

Top module: `spi_port`

## Requirements
- R1: After reset the control register, the status register and the data read value are all 0x00. `irq` and `sck_oe` are 0.
- R2: In the master role (control bit 7 = 1), a data register write (address 2) while idle sends that byte MSB first on `sdo` and captures the 8 bits on `sdi` into the data read value. The transfer uses exactly 16 SCK edges. SCK idles at the polarity bit (control bit 5). With phase 0 (control bit 4), data is sampled on edges 1, 3, 5 and so on. With phase 1, data is sampled on edges 2, 4, 6 and so on.
- R3: In the master role, SCK half period = (2 << d) system clocks, where d is control bits 2:0. Values of d above 5 act as 5.
- R4: In the slave role with select active, the unit shifts its loaded byte out on `sdo` and captures 8 bits from `sdi`. It uses the edges of the synchronized `sck_in` and the same polarity and phase rules as R2.
- R5: In the slave role, an inactive (high) select clears any partial byte. A partial byte does not set the completion flag. The next full byte is received correctly.
- R6: The completion flag (status bit 7) is set when a byte ends. `irq` = interrupt enable (control bit 6) AND completion flag. While the interrupt is enabled, only an `irq_ack` pulse clears the flag.
- R7: While the interrupt is disabled, a data register access alone does not clear the completion flag. The flag clears on a status read that sees it set, followed later by a data read or data write.
- R8: A data write during a transfer is ignored and sets the collision flag (status bit 6). Writing 0 to status bit 6 clears that flag.
- R9: In the master role with select-enable (status bit 4) set, a low select clears control bit 7, sets the completion flag, stops the transfer and drops `sck_oe`.
- R10: With select-enable clear, `sel_in` is ignored. The master does not fall back to slave, and the slave acts as if selected.
- R11: With select-enable set, a high select sets status bit 5. Writing 0 to that bit clears it, and writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| sck_out | output | 1 | Generated serial clock (master role) |
| sck_oe | output | 1 | High while the unit is in the master role and drives SCK |
| sck_in | input | 1 | External serial clock (slave role) |
| sel_in | input | 1 | Active-low select input |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions check the following rules on every cycle:
- the fallback from master to slave on a conflicting select;
- that an idle data write starts the master engine;
- that a data write during a transfer raises the collision flag;
- that a deselected slave holds its bit counter at zero;
- that the completion flag stays set while the interrupt is off and no status read has armed the clear.

Only the bench scenarios can show the rest:
- the bit order;
- the sample and change edges in each polarity and phase combination;
- the SCK period for each divider setting;
- correct slave reception after an aborted partial byte.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       irq_ack,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       sck_in,
  input  logic       sel_in,
  output logic       sdo,
  input  logic       sdi
);
  logic       master, ien, cpol, cpha;
  logic [2:0] div;
  logic       done, wcol, selhi, sel_en, armed;
  logic       busy_m, sck_r;
  logic [6:0] cnt;
  logic [3:0] k;
  logic [7:0] tx, rx, rdbuf;
  logic [2:0] sck_s;
  logic [1:0] sel_s, sdi_s;

  logic [2:0] dsel;
  logic [6:0] half;
  logic       sel_int, fault, tick_m, edge_s, step, din, samp, shf, busy;
  logic       dwr, swr, acc_data, start, unused_bits;

  assign dsel     = (div > 3'd5) ? 3'd5 : div;
  assign half     = 7'd2 << dsel;
  assign sel_int  = sel_en ? sel_s[1] : master;
  assign fault    = master & sel_en & ~sel_s[1];
  assign tick_m   = busy_m & (cnt == half - 7'd1);
  assign edge_s   = ~master & ~sel_int & (sck_s[1] ^ sck_s[2]);
  assign step     = tick_m | edge_s;
  assign din      = master ? sdi : sdi_s[1];
  assign samp     = (k[0] == cpha);
  assign shf      = ~samp & ~(cpha & (k == 4'd0));
  assign busy     = master ? busy_m : (k != 4'd0);
  assign dwr      = bus_wr & (bus_addr == 2'd2);
  assign swr      = bus_wr & (bus_addr == 2'd1);
  assign acc_data = (bus_wr | bus_rd) & (bus_addr == 2'd2);
  assign start    = dwr & ~busy;
  assign unused_bits = bus_wdata[3];

  assign irq     = ien & done;
  assign sdo     = tx[7];
  assign sck_out = busy_m ? sck_r : cpol;
  assign sck_oe  = master;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {master, ien, cpol, cpha, 1'b0, div};
      2'd1:    bus_rdata = {done, wcol, selhi, sel_en, 3'b000, busy};
      2'd2:    bus_rdata = rdbuf;
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= 3'b000;
      sel_s <= 2'b11;
      sdi_s <= 2'b00;
    end else begin
      sck_s <= {sck_s[1:0], sck_in};
      sel_s <= {sel_s[0], sel_in};
      sdi_s <= {sdi_s[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master <= 1'b0; ien <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; div <= 3'd0;
    end else if (fault) begin
      master <= 1'b0;
    end else if (bus_wr && bus_addr == 2'd0) begin
      master <= bus_wdata[7];
      ien    <= bus_wdata[6];
      cpol   <= bus_wdata[5];
      cpha   <= bus_wdata[4];
      div    <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b0; sck_r <= 1'b0; cnt <= 7'd0; k <= 4'd0;
      tx <= 8'h00; rx <= 8'h00; rdbuf <= 8'h00;
    end else if (fault) begin
      busy_m <= 1'b0;
      k      <= 4'd0;
    end else if (!master && sel_int) begin
      k  <= 4'd0;
      rx <= 8'h00;
      if (start) tx <= bus_wdata;
    end else if (start) begin
      tx <= bus_wdata;
      k  <= 4'd0;
      if (master) begin
        busy_m <= 1'b1;
        cnt    <= 7'd0;
        sck_r  <= cpol;
      end
    end else begin
      if (busy_m) cnt <= tick_m ? 7'd0 : cnt + 7'd1;
      if (step) begin
        k <= k + 4'd1;
        if (master) sck_r <= ~sck_r;
        if (samp) rx <= {rx[6:0], din};
        if (shf) tx <= {tx[6:0], 1'b0};
        if (k == 4'd15) begin
          rdbuf  <= samp ? {rx[6:0], din} : rx;
          busy_m <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; armed <= 1'b0; wcol <= 1'b0; selhi <= 1'b0; sel_en <= 1'b0;
    end else begin
      if ((step && k == 4'd15 && !(!master && sel_int)) || fault)
        done <= 1'b1;
      else if (ien ? irq_ack : (armed & acc_data))
        done <= 1'b0;

      if (bus_rd && bus_addr == 2'd1 && done) armed <= 1'b1;
      else if (acc_data || !done)             armed <= 1'b0;

      if (dwr && busy)                  wcol <= 1'b1;
      else if (swr && !bus_wdata[6])    wcol <= 1'b0;

      if (sel_en && sel_s[1])           selhi <= 1'b1;
      else if (swr && !bus_wdata[5])    selhi <= 1'b0;

      if (swr) sel_en <= bus_wdata[4];
    end
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master,
  input logic       sel_en,
  input logic       sel_sync,
  input logic       sel_int,
  input logic       done,
  input logic       ien,
  input logic       armed,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       busy,
  input logic       busy_m,
  input logic       wcol,
  input logic [3:0] k
);
  p_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (master && sel_en && !sel_sync) |=> (!master && done && !busy_m));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && master && !busy && !(sel_en && !sel_sync)) |=> busy_m);

  p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && busy) |=> wcol);

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && sel_int) |=> (k == 4'd0));

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ien && !armed) |=> done);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .sel_en(sel_en),
  .sel_sync(sel_s[1]), .sel_int(sel_int), .done(done), .ien(ien),
  .armed(armed), .bus_wr(bus_wr), .bus_addr(bus_addr), .busy(busy),
  .busy_m(busy_m), .wcol(wcol), .k(k)
);

// File: tb/spi_port_test.sv
module spi_port_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, irq_ack = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, sck_out, sck_oe, sdo;
  logic       sck_in = 1'b0, sel_in = 1'b1, sdi_r = 1'b0;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .irq_ack(irq_ack),
    .sck_out(sck_out), .sck_oe(sck_oe), .sck_in(sck_in), .sel_in(sel_in),
    .sdo(sdo), .sdi(sdi_r)
  );

  int errs = 0, checks = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // external device model for master-role transfers
  logic       dev_on = 1'b0, dcpha = 1'b0;
  int         dev_k = 0;
  logic [7:0] dev_tx = 8'h00, dev_rx = 8'h00;
  time        t_e0 = 0, t_e1 = 0;

  always @(sck_out) begin
    if (dev_on) begin
      if (dev_k == 0) t_e0 = $time;
      if (dev_k == 1) t_e1 = $time;
      if ((dev_k % 2) == int'(dcpha)) dev_rx = {dev_rx[6:0], sdo};
      else if (!(dcpha && dev_k == 0)) dev_tx = {dev_tx[6:0], 1'b0};
      sdi_r = dev_tx[7];
      dev_k++;
    end
  end

  task automatic master_xfer(input logic [7:0] cb, input logic [7:0] db,
                             input logic cp, input logic ch, input logic [2:0] dv,
                             input logic ie, input string tag);
    logic [7:0] s, r;
    int g, hexp;
    wr_reg(2'd0, {1'b1, ie, cp, ch, 1'b0, dv});
    dcpha = ch; dev_tx = db; sdi_r = db[7]; dev_rx = 8'h00; dev_k = 0; dev_on = 1'b1;
    wr_reg(2'd2, cb);
    g = 0;
    do begin rd_reg(2'd1, s); g++; end while (!s[7] && g < 5000);
    dev_on = 1'b0;
    rd_reg(2'd2, r);
    hexp = (2 << ((dv > 3'd5) ? 5 : int'(dv))) * 20;
    chk({tag, " R2 rx"}, r, db);
    chk({tag, " R2 tx"}, dev_rx, cb);
    chk({tag, " R2 edges"}, dev_k, 16);
    chk({tag, " R2 idle"}, sck_out, cp);
    chk({tag, " R3 half"}, int'(t_e1 - t_e0), hexp);
  endtask

  task automatic slave_xfer(input logic [7:0] cb, input logic [7:0] mb,
                            input logic cp, input logic ch, input logic drive_sel,
                            output logic [7:0] got);
    logic [7:0] m;
    wr_reg(2'd2, cb);
    sck_in = cp;
    if (drive_sel) sel_in = 1'b0;
    m = mb; sdi_r = m[7]; got = 8'h00;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      if ((i % 2) == int'(ch)) got = {got[6:0], sdo};
      sck_in = ~sck_in;
      if ((i % 2) != int'(ch)) begin
        if (!(ch && i == 0)) m = {m[6:0], 1'b0};
        sdi_r = m[7];
      end
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, got;
    int g;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 status", v, 8'h00);
    rd_reg(2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 sck_oe", sck_oe, 0);

    // R2/R3 master sweep over all modes, dividers and three patterns
    for (int md = 0; md < 4; md++)
      for (int dv = 0; dv < 6; dv++)
        for (int p = 0; p < 3; p++) begin
          logic [7:0] cb, db;
          cb = 8'(8'hA5 ^ (md * 37 + dv * 11 + p * 73));
          db = 8'((cb * 5 + 8'h3C) ^ (p * 8'h81));
          master_xfer(cb, db, md[1], md[0], 3'(dv), 1'b0, "sweep");
        end
    chk("R2 sck_oe master", sck_oe, 1);
    // R3 divider clamp
    master_xfer(8'h1E, 8'hE1, 1'b0, 1'b0, 3'd7, 1'b0, "clamp");

    // R6 interrupt path
    wr_reg(2'd0, 8'hC0);
    dev_tx = 8'h00; dev_k = 0; dcpha = 1'b0; dev_on = 1'b1;
    wr_reg(2'd2, 8'h42);
    g = 0;
    while (!irq && g < 2000) begin @(negedge clk); g++; end
    dev_on = 1'b0;
    chk("R6 irq raised", irq, 1);
    rd_reg(2'd1, v); rd_reg(2'd2, v);
    rd_reg(2'd1, v); chk("R6 flag kept without ack", v[7], 1);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R6 irq after ack", irq, 0);
    rd_reg(2'd1, v); chk("R6 flag after ack", v[7], 0);

    // R8 write collision
    wr_reg(2'd0, 8'h85);
    dev_tx = 8'h99; sdi_r = 1'b1; dev_rx = 8'h00; dev_k = 0; dcpha = 1'b0; dev_on = 1'b1;
    wr_reg(2'd2, 8'h3C);
    repeat (20) @(negedge clk);
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd1, v); chk("R8 collision flag", v[6], 1);
    g = 0;
    do begin rd_reg(2'd1, v); g++; end while (!v[7] && g < 5000);
    dev_on = 1'b0;
    chk("R8 ignored write tx", dev_rx, 8'h3C);
    rd_reg(2'd2, v); chk("R8 ignored write rx", v, 8'h99);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd1, v); chk("R8 collision cleared", v[6], 0);

    // R9 mode fault
    sel_in = 1'b1;
    wr_reg(2'd1, 8'h10);
    wr_reg(2'd0, 8'h85);
    wr_reg(2'd2, 8'h81);
    repeat (30) @(negedge clk);
    sel_in = 1'b0;
    repeat (6) @(negedge clk);
    rd_reg(2'd0, v); chk("R9 role cleared", v[7], 0);
    rd_reg(2'd1, v); chk("R9 flag set", v[7], 1); chk("R9 stopped", v[0], 0);
    chk("R9 sck_oe", sck_oe, 0);
    rd_reg(2'd2, v);
    sel_in = 1'b1;
    repeat (4) @(negedge clk);

    // R10 master ignores select when disabled
    wr_reg(2'd1, 8'h00);
    sel_in = 1'b0;
    master_xfer(8'h6D, 8'hB2, 1'b1, 1'b1, 3'd1, 1'b0, "nosel");
    rd_reg(2'd0, v); chk("R10 master kept", v[7], 1);
    sel_in = 1'b1;

    // R4/R7 slave sweep
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd1, 8'h10);
    for (int md = 0; md < 4; md++)
      for (int p = 0; p < 3; p++) begin
        logic [7:0] cb, mb;
        cb = 8'(8'h5C + md * 29 + p * 67);
        mb = 8'(~cb ^ (p * 8'h24));
        sel_in = 1'b1;
        wr_reg(2'd0, {2'b00, md[1], md[0], 4'h0});
        sck_in = md[1];
        repeat (4) @(negedge clk);
        slave_xfer(cb, mb, md[1], md[0], 1'b1, got);
        chk("R4 slave tx", got, cb);
        rd_reg(2'd2, v); chk("R4 slave rx", v, mb);
        chk("R6 no irq when disabled", irq, 0);
        rd_reg(2'd1, v); chk("R7 data access alone keeps flag", v[7], 1);
        rd_reg(2'd2, v);
        rd_reg(2'd1, v); chk("R7 flag cleared by sequence", v[7], 0);
        sel_in = 1'b1;
      end

    // R5 partial byte then deselect
    wr_reg(2'd0, 8'h00);
    sck_in = 1'b0;
    repeat (4) @(negedge clk);
    wr_reg(2'd2, 8'h5A);
    sel_in = 1'b0; sdi_r = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 5; i++) begin sck_in = ~sck_in; repeat (8) @(negedge clk); end
    sel_in = 1'b1; sck_in = 1'b0;
    repeat (8) @(negedge clk);
    rd_reg(2'd1, v); chk("R5 no flag on partial", v[7], 0);
    slave_xfer(8'hC3, 8'h96, 1'b0, 1'b0, 1'b1, got);
    chk("R5 tx after abort", got, 8'hC3);
    rd_reg(2'd2, v); chk("R5 rx after abort", v, 8'h96);
    rd_reg(2'd1, v); rd_reg(2'd2, v);
    sel_in = 1'b1;
    repeat (4) @(negedge clk);

    // R10 slave with select disabled and select held high
    wr_reg(2'd1, 8'h00);
    slave_xfer(8'h27, 8'hD8, 1'b0, 1'b1, 1'b0, got);
    chk("R10 slave tx", got, 8'h27);
    rd_reg(2'd2, v); chk("R10 slave rx", v, 8'hD8);
    rd_reg(2'd1, v); rd_reg(2'd2, v);

    // R11 sticky select-high flag
    wr_reg(2'd1, 8'h10);
    repeat (4) @(negedge clk);
    rd_reg(2'd1, v); chk("R11 flag set", v[5], 1);
    sel_in = 1'b0;
    repeat (4) @(negedge clk);
    wr_reg(2'd1, 8'h10);
    rd_reg(2'd1, v); chk("R11 cleared by 0", v[5], 0);
    wr_reg(2'd1, 8'h30);
    rd_reg(2'd1, v); chk("R11 write 1 no set", v[5], 0);
    sel_in = 1'b1;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule